// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block collects interrupt requests from three peripheral sources into a pending-status register and holds a CPU-owned enable mask next to it. The single CPU interrupt line is high whenever any status bit is set whose mask bit is also set. Software reaches both registers through a small register interface addressed by a byte offset inside the I/O window. Both 16-bit and 32-bit writes are accepted.

Software acknowledges an interrupt by writing to the status register. The written word is ANDed into the register, so a zero bit clears the matching pending bit and a one bit leaves it alone. A write to the mask register replaces the mask. The interrupt line is a combinational function of the two registers, so it follows a mask change in the same cycle that the new mask is registered.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset both registers read as zero and `cpu_irq` is low.
- R2: A one-cycle pulse on `req_dma` sets status bit 3, on `req_serial` sets status bit 7, and on `req_audio` sets status bit 9. The bit is visible from the next clock edge on.
- R3: A write to offset 0x070 sets the status register to the old status AND the written value, applied to the written lanes.
- R4: A request pulse in the same cycle as a status write wins, and its status bit is set after that edge even if the written value has a zero there.
- R5: A write to offset 0x074 stores the written value in the mask register, applied to the written lanes.
- R6: `cpu_irq` equals the OR over all bits of (status AND mask). After a mask write that makes this nonzero, it is high in the cycle right after that edge.
- R7: A write with `wr_wide`=0 (16-bit) changes only bits 15:0 of the addressed register, and bits 31:16 keep their value. With `wr_wide`=1 (32-bit), all 32 bits are written.
- R8: A write to any offset other than 0x070 or 0x074 changes neither register. This includes the upper-half offsets 0x072 and 0x076.
- R9: `rd_data` returns the status register for `rd_addr`=0x070, the mask register for 0x074, and zero for every other offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_dma | input | 1 | DMA request pulse (status bit 3) |
| req_serial | input | 1 | Serial-port request pulse (status bit 7) |
| req_audio | input | 1 | Audio request pulse (status bit 9) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Byte offset of the write |
| wr_wide | input | 1 | 1 = 32-bit write, 0 = 16-bit write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 12 | Byte offset of the read |
| rd_data | output | 32 | Read data (combinational) |
| cpu_irq | output | 1 | Interrupt request to the CPU |

## Verification
Directed cases check each source in turn, so a bit-position swap between sources shows up. They also check a status write that collides with a request, which separates request priority from plain AND acknowledgement. A mask write that unmasks an already-pending bit is checked for the interrupt rising one edge later. Halfword writes to both registers are paired with upper-half offsets, which separates lane masking from address decoding. Random stimulus then mixes requests, both widths and a set of legal and stray offsets, with a model that tracks both registers every cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int IRQC_W   = 32;
    localparam int HALF_W   = 16;
    localparam int NUM_SRC  = 3;
    // status bit set by each request source: dma, serial, audio
    localparam int SRC_BIT [NUM_SRC] = '{3, 7, 9};

    typedef struct packed {
        logic [IRQC_W-1:0] status;
        logic [IRQC_W-1:0] mask;
    } irqc_regs_t;
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode #(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int LOW_W      = 16,
    parameter logic [ADDR_W-1:0] STATUS_OFS = 12'h070,
    parameter logic [ADDR_W-1:0] MASK_OFS   = 12'h074
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_wide,
    output logic              hit_status,
    output logic              hit_mask,
    output logic [DATA_W-1:0] lane_mask
);
    assign hit_status = wr_en && (wr_addr == STATUS_OFS);
    assign hit_mask   = wr_en && (wr_addr == MASK_OFS);

    for (genvar i = 0; i < DATA_W; i++) begin : g_lane
        if (i < LOW_W) begin : g_low
            assign lane_mask[i] = 1'b1;
        end else begin : g_high
            assign lane_mask[i] = wr_wide;
        end
    end
endmodule

// File: rtl/irqc_srcmap.sv
module irqc_srcmap
    import irqc_pkg::*;
(
    input  logic [NUM_SRC-1:0] req,
    output logic [IRQC_W-1:0]  set_vec
);
    logic [NUM_SRC-1:0][IRQC_W-1:0] part;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        assign part[s] = {{(IRQC_W-1){1'b0}}, req[s]} << SRC_BIT[s];
    end

    always_comb begin
        set_vec = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            set_vec = set_vec | part[s];
        end
    end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_status,
    input  logic              hit_mask,
    input  logic [IRQC_W-1:0] lane_mask,
    input  logic [IRQC_W-1:0] wdata,
    input  logic [IRQC_W-1:0] set_vec,
    output logic [IRQC_W-1:0] status_q,
    output logic [IRQC_W-1:0] mask_q
);
    irqc_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (hit_status) begin
            // unwritten lanes keep their bits; written lanes are ANDed
            regs_d.status = regs_q.status & (wdata | ~lane_mask);
        end
        // requests come after the acknowledge so they win a collision
        regs_d.status = regs_d.status | set_vec;
        if (hit_mask) begin
            regs_d.mask = (regs_q.mask & ~lane_mask) | (wdata & lane_mask);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign status_q = regs_q.status;
    assign mask_q   = regs_q.mask;
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import irqc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] STATUS_OFS = 12'h070,
    parameter logic [ADDR_W-1:0] MASK_OFS   = 12'h074
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_dma,
    input  logic              req_serial,
    input  logic              req_audio,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_wide,
    input  logic [IRQC_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [IRQC_W-1:0] rd_data,
    output logic              cpu_irq
);
    logic              hit_status, hit_mask;
    logic [IRQC_W-1:0] lane_mask, set_vec;
    logic [IRQC_W-1:0] status_q, mask_q;
    logic [NUM_SRC-1:0] req_vec;

    assign req_vec = {req_audio, req_serial, req_dma};

    irqc_decode #(
        .ADDR_W(ADDR_W), .DATA_W(IRQC_W), .LOW_W(HALF_W),
        .STATUS_OFS(STATUS_OFS), .MASK_OFS(MASK_OFS)
    ) u_decode (
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_wide(wr_wide),
        .hit_status(hit_status), .hit_mask(hit_mask), .lane_mask(lane_mask)
    );

    irqc_srcmap u_srcmap (.req(req_vec), .set_vec(set_vec));

    irqc_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .hit_status(hit_status), .hit_mask(hit_mask),
        .lane_mask(lane_mask), .wdata(wr_data), .set_vec(set_vec),
        .status_q(status_q), .mask_q(mask_q)
    );

    always_comb begin
        if (rd_addr == STATUS_OFS)    rd_data = status_q;
        else if (rd_addr == MASK_OFS) rd_data = mask_q;
        else                          rd_data = '0;
    end

    assign cpu_irq = |(status_q & mask_q);
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] STATUS_OFS = 12'h070,
    parameter logic [ADDR_W-1:0] MASK_OFS   = 12'h074
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_dma,
    input logic              req_serial,
    input logic              req_audio,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              wr_wide,
    input logic [31:0]       wr_data,
    input logic [31:0]       status_q,
    input logic [31:0]       mask_q,
    input logic              cpu_irq
);
    logic any_req, w_stat, w_mask;
    assign any_req = req_dma | req_serial | req_audio;
    assign w_stat  = wr_en && (wr_addr == STATUS_OFS);
    assign w_mask  = wr_en && (wr_addr == MASK_OFS);

    assert_src_dma_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_dma |=> status_q[3]);
    assert_src_serial_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_serial |=> status_q[7]);
    assert_src_audio_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_audio |=> status_q[9]);
    assert_ack_and_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (w_stat && wr_wide && !any_req) |=> status_q == ($past(status_q) & $past(wr_data)));
    assert_req_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (w_stat && req_serial) |=> status_q[7]);
    assert_mask_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (w_mask && wr_wide) |=> mask_q == $past(wr_data));
    assert_irq_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (w_mask && wr_wide && !w_stat && |(status_q & wr_data)) |=> cpu_irq);
    assert_half_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (w_mask && !wr_wide) |=> mask_q[31:16] == $past(mask_q[31:16]));
    assert_stray_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!w_stat && !w_mask && !any_req) |=> ($stable(status_q) && $stable(mask_q)));
endmodule

bind irq_status_ctrl irqc_checker #(
    .ADDR_W(ADDR_W), .STATUS_OFS(STATUS_OFS), .MASK_OFS(MASK_OFS)
) u_irqc_checker (
    .clk(clk), .rst_n(rst_n),
    .req_dma(req_dma), .req_serial(req_serial), .req_audio(req_audio),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_wide(wr_wide), .wr_data(wr_data),
    .status_q(status_q), .mask_q(mask_q), .cpu_irq(cpu_irq)
);

// File: tb/irq_status_ctrl_bench.sv
`timescale 1ns/1ps
module irq_status_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_dma = 0, req_serial = 0, req_audio = 0;
    logic        wr_en = 0, wr_wide = 0;
    logic [11:0] wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        cpu_irq;

    int checks = 0, failures = 0;
    bit done = 0;
    logic [31:0] m_status = '0, m_mask = '0;

    always #2.5 clk = ~clk;

    irq_status_ctrl u_irq_status_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_dma(req_dma), .req_serial(req_serial), .req_audio(req_audio),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_wide(wr_wide), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .cpu_irq(cpu_irq)
    );

    function automatic logic [31:0] lanes(input logic wide);
        return wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    endfunction

    function automatic logic [31:0] nxt_status(input logic [31:0] s, input logic we,
        input logic [11:0] a, input logic wide, input logic [31:0] d, input logic [2:0] rq);
        logic [31:0] r;
        r = s;
        if (we && a == 12'h070) r = s & (d | ~lanes(wide));
        r = r | ({31'd0, rq[0]} << 3) | ({31'd0, rq[1]} << 7) | ({31'd0, rq[2]} << 9);
        return r;
    endfunction

    function automatic logic [31:0] nxt_mask(input logic [31:0] m, input logic we,
        input logic [11:0] a, input logic wide, input logic [31:0] d);
        if (we && a == 12'h074) return (m & ~lanes(wide)) | (d & lanes(wide));
        return m;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // reads both registers and the irq line, compares with the model
    task automatic verify(input string tag);
        rd_addr = 12'h070; #0.2;
        chk({tag, " status"}, rd_data, m_status);
        rd_addr = 12'h074; #0.2;
        chk({tag, " mask"}, rd_data, m_mask);
        chk({tag, " R6 irq"}, {31'd0, cpu_irq}, {31'd0, |(m_status & m_mask)});
    endtask

    // drives one cycle of stimulus, called just after a falling edge
    task automatic cycle(input logic we, input logic [11:0] a, input logic wide,
                         input logic [31:0] d, input logic [2:0] rq, input string tag);
        wr_en = we; wr_addr = a; wr_wide = wide; wr_data = d;
        {req_audio, req_serial, req_dma} = rq;
        @(posedge clk); #1;
        m_status = nxt_status(m_status, we, a, wide, d, rq);
        m_mask   = nxt_mask(m_mask, we, a, wide, d);
        wr_en = 0; {req_audio, req_serial, req_dma} = 3'b000;
        verify(tag);
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [11:0] offs [5];
        int unsigned seed;
        offs = '{12'h070, 12'h074, 12'h072, 12'h076, 12'h078};
        seed = $urandom(32'h1F80);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        verify("R1 reset");
        rd_addr = 12'h000; #0.2;
        chk("R9 unmapped read", rd_data, 32'h0);

        cycle(0, 12'h000, 1, 0, 3'b001, "R2 dma");
        chk("R2 bit3", m_status, 32'h0000_0008);
        cycle(0, 12'h000, 1, 0, 3'b010, "R2 serial");
        cycle(0, 12'h000, 1, 0, 3'b100, "R2 audio");
        cycle(1, 12'h070, 1, 32'hFFFF_FF7F, 3'b000, "R3 ack bit7");
        cycle(1, 12'h070, 1, 32'h0000_0000, 3'b001, "R4 collision");
        cycle(1, 12'h074, 1, 32'h0000_0008, 3'b000, "R5 R6 unmask pending");
        chk("R6 irq high after mask write", {31'd0, cpu_irq}, 32'd1);
        cycle(1, 12'h074, 1, 32'hABCD_0000, 3'b000, "R5 wide mask");
        cycle(1, 12'h074, 0, 32'h1234_5678, 3'b000, "R7 half mask");
        rd_addr = 12'h074; #0.2;
        chk("R7 upper kept", rd_data, 32'hABCD_5678);
        cycle(1, 12'h076, 0, 32'h0000_0000, 3'b000, "R8 upper offset");
        cycle(1, 12'h072, 0, 32'h0000_0000, 3'b000, "R8 status upper offset");
        cycle(1, 12'h078, 1, 32'h0000_0000, 3'b000, "R8 stray offset");
        cycle(1, 12'h070, 0, 32'hFFFF_0000, 3'b000, "R7 R3 half ack");

        for (int i = 0; i < 400; i++) begin
            logic [11:0] a;
            a = offs[$urandom % 5];
            cycle($urandom % 2 == 0, a, 1'($urandom), $urandom, 3'($urandom % 8 == 0 ? $urandom : 0),
                  "R3 R5 R7 R8 random");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule